// File: doc/BRIEF.md
# Nibble-Flag 8-bit ALU

This is a purely combinational arithmetic and logic unit for an accumulator-style processor core. It takes an operation code, two 8-bit operands, the present carry and zero flags and a carry-update enable. From these it returns an 8-bit result, a strobe that says whether the result should be written back, and the next values of the zero, subtract, half-carry and carry flags. The sequencer that owns the flag register feeds the outputs back on its next cycle.

The adder is split at the nibble boundary, so the carry or borrow between bit 3 and bit 4 comes out as the half-carry flag. A compare runs the subtractor and sets the flags but suppresses the write strobe. A wide mode adds two 16-bit register pairs. In that mode the half-carry comes from bit 11 and the carry from bit 15, and the zero flag passes through unchanged.

Top module: `nib_alu`

## Requirements
- R1: With `wide_i`=0, op code 0 (add) gives `res_o` = a+b mod 256, and op code 1 (add with carry) gives `res_o` = a+b+`carry_i` mod 256.
- R2: With `wide_i`=0, op code 2 (subtract) and op code 4 (compare) give `res_o` = a-b mod 256, and op code 3 (subtract with carry) gives `res_o` = a-b-`carry_i` mod 256. `carry_i` has no effect on op codes 0, 2 and 4.
- R3: For op codes 0 to 4, `half_o` is the carry out of, or the borrow into, the low 4-bit stage, with the same carry-in as R1 and R2.
- R4: Op code 5 (AND) always sets `half_o`=1. Op codes 6 (OR) and 7 (XOR) set `half_o`=0. Op codes 5, 6 and 7 give a&b, a|b and a^b.
- R5: With `wide_i`=0, `sub_o` is 1 for op codes 2, 3 and 4 and 0 for all others.
- R6: `res_we_o` is 0 for op code 4 and for wide mode, and 1 for every other 8-bit op.
- R7: With `wide_i`=0 and `upd_carry_i`=0, `carry_o` equals `carry_i`. With `upd_carry_i`=1, `carry_o` is the carry or borrow out of bit 7 for op codes 0 to 4, and 0 for op codes 5 to 7.
- R8: With `wide_i`=0, `zero_o` is 1 exactly when the 8-bit result of R1, R2 or R4 is 0. This holds for compare as well.
- R9: With `wide_i`=1, `wsum_o` = wa+wb mod 65536, `sub_o`=0, `half_o` is the carry out of bit 11, `carry_o` is the carry out of bit 15 regardless of `upd_carry_i`, and `zero_o` equals `zero_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (0 add, 1 add+carry, 2 sub, 3 sub+carry, 4 compare, 5 and, 6 or, 7 xor) |
| wide_i | input | 1 | Select 16-bit pair add |
| a_i | input | 8 | First 8-bit operand |
| b_i | input | 8 | Second 8-bit operand |
| wa_i | input | 16 | First 16-bit operand |
| wb_i | input | 16 | Second 16-bit operand |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| upd_carry_i | input | 1 | Allow 8-bit ops to change carry |
| res_o | output | 8 | 8-bit result |
| res_we_o | output | 1 | Write strobe for the 8-bit result |
| wsum_o | output | 16 | 16-bit sum |
| zero_o | output | 1 | Next zero flag |
| sub_o | output | 1 | Next subtract flag |
| half_o | output | 1 | Next half-carry flag |
| carry_o | output | 1 | Next carry flag |

## Verification
Hand-picked vectors target the carry chain. Operands such as 0x0F+0x01 and 0x10-0x01 make the nibble carry differ from the byte carry, and 0x3A+0xC6 produces both at once with a zero result. A sweep then crosses every op code with operands at the nibble and byte edges, with both carry-in values and both update settings. That sweep separates ops that honour the incoming carry from ops that ignore it, and a held carry from an updated one. The wide-mode vectors carry into bit 12 only, carry out of bit 16 only, and wrap to zero with the zero flag clear. This shows that half-carry and carry come from bits 11 and 15, and that the zero flag is passed through rather than recomputed.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_CP  = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;
endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o,
  output logic              cout_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam int HI_W  = DATA_W - NIB_W;

  logic [NIB_W:0] lo;
  logic [HI_W:0]  hi;

  // top bit of each stage is carry (add) or borrow (sub)
  always_comb begin
    if (sub_i) begin
      lo = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - (NIB_W+1)'(cin_i);
      hi = {1'b0, a_i[DATA_W-1:NIB_W]} - {1'b0, b_i[DATA_W-1:NIB_W]} - (HI_W+1)'(lo[NIB_W]);
    end else begin
      lo = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + (NIB_W+1)'(cin_i);
      hi = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, b_i[DATA_W-1:NIB_W]} + (HI_W+1)'(lo[NIB_W]);
    end
  end

  assign res_o  = {hi[HI_W-1:0], lo[NIB_W-1:0]};
  assign half_o = lo[NIB_W];
  assign cout_o = hi[HI_W];
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic
  import nib_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end

  assign half_o = (op_i == OP_AND);
endmodule

// File: rtl/nib_alu_wide.sv
module nib_alu_wide #(
  parameter int WIDE_W = 16
) (
  input  logic [WIDE_W-1:0] a_i,
  input  logic [WIDE_W-1:0] b_i,
  output logic [WIDE_W-1:0] sum_o,
  output logic              half_o,
  output logic              cout_o
);
  localparam int HALF_BIT = WIDE_W - 4;

  logic [HALF_BIT:0] part;
  logic [WIDE_W:0]   full;

  assign part   = {1'b0, a_i[HALF_BIT-1:0]} + {1'b0, b_i[HALF_BIT-1:0]};
  assign full   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o  = full[WIDE_W-1:0];
  assign half_o = part[HALF_BIT];
  assign cout_o = full[WIDE_W];
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]          op_i,
  input  logic                wide_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [2*DATA_W-1:0] wa_i,
  input  logic [2*DATA_W-1:0] wb_i,
  input  logic                carry_i,
  input  logic                zero_i,
  input  logic                upd_carry_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                res_we_o,
  output logic [2*DATA_W-1:0] wsum_o,
  output logic                zero_o,
  output logic                sub_o,
  output logic                half_o,
  output logic                carry_o
);
  localparam int WIDE_W = 2 * DATA_W;

  alu_op_e op;
  logic    is_logic, is_sub, use_cin;
  logic [DATA_W-1:0] ar_res, lg_res;
  logic    ar_half, ar_cout, lg_half, w_half, w_cout;

  assign op       = alu_op_e'(op_i);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
  assign use_cin  = ((op == OP_ADC) || (op == OP_SBC)) && carry_i;

  nib_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i(a_i), .b_i(b_i), .cin_i(use_cin), .sub_i(is_sub),
    .res_o(ar_res), .half_o(ar_half), .cout_o(ar_cout)
  );

  nib_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lg_res), .half_o(lg_half)
  );

  nib_alu_wide #(.WIDE_W(WIDE_W)) u_wide (
    .a_i(wa_i), .b_i(wb_i), .sum_o(wsum_o), .half_o(w_half), .cout_o(w_cout)
  );

  assign res_o = is_logic ? lg_res : ar_res;

  always_comb begin
    if (wide_i) begin
      res_we_o = 1'b0;
      zero_o   = zero_i;
      sub_o    = 1'b0;
      half_o   = w_half;
      carry_o  = w_cout;
    end else begin
      res_we_o = (op != OP_CP);
      zero_o   = (res_o == '0);
      sub_o    = is_sub;
      half_o   = is_logic ? lg_half : ar_half;
      carry_o  = !upd_carry_i ? carry_i : (is_logic ? 1'b0 : ar_cout);
    end
  end

  always_comb begin
    if (!wide_i && op_i == 3'd4) begin
      a_r6_cp_no_write: assert (!res_we_o);
    end
    if (!wide_i && !upd_carry_i) begin
      a_r7_carry_hold: assert (carry_o == carry_i);
    end
    if (!wide_i && op_i == 3'd5) begin
      a_r4_and_half: assert (half_o);
    end
    if (!wide_i) begin
      a_r8_zero_match: assert (zero_o == (res_o == '0));
    end
    if (wide_i) begin
      a_r9_wide_flags: assert (zero_o == zero_i && !sub_o && !res_we_o);
    end
    if (!wide_i && upd_carry_i && op_i >= 3'd5) begin
      a_r7_logic_clear: assert (!carry_o);
    end
  end
endmodule

// File: tb/nib_alu_tb.sv
module nib_alu_tb;
  logic        clk = 1'b0;
  logic [2:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic [7:0]  a_i = '0, b_i = '0;
  logic [15:0] wa_i = '0, wb_i = '0;
  logic        carry_i = 1'b0, zero_i = 1'b0, upd_carry_i = 1'b0;
  logic [7:0]  res_o;
  logic [15:0] wsum_o;
  logic        res_we_o, zero_o, sub_o, half_o, carry_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  nib_alu u_dut (
    .op_i(op_i), .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .wa_i(wa_i), .wb_i(wb_i),
    .carry_i(carry_i), .zero_i(zero_i), .upd_carry_i(upd_carry_i),
    .res_o(res_o), .res_we_o(res_we_o), .wsum_o(wsum_o),
    .zero_o(zero_o), .sub_o(sub_o), .half_o(half_o), .carry_o(carry_o)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] a, b;
    logic       cin, upd;
    logic [7:0] res;
    logic       we, z, n, h, c;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 8'h3A, 8'hC6, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{3'd1, 8'h0F, 8'h00, 1'b1, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd2, 8'h10, 8'h01, 1'b0, 1'b1, 8'h0F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{3'd3, 8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd4, 8'h42, 8'h42, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd5, 8'hF0, 8'h0F, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{3'd6, 8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{3'd7, 8'hAA, 8'h55, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd0, 8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{3'd2, 8'h20, 8'h30, 1'b0, 1'b1, 8'hF0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (op %0d a %0h b %0h cin %0b upd %0b)",
               tag, act, exp, op_i, a_i, b_i, carry_i, upd_carry_i);
    end
  endtask

  function automatic string res_tag(input logic [2:0] op);
    if (op <= 3'd1) return "R1";
    if (op <= 3'd4) return "R2";
    return "R4";
  endfunction

  function automatic string half_tag(input logic [2:0] op);
    return (op <= 3'd4) ? "R3" : "R4";
  endfunction

  task automatic apply8(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic cin, input logic upd);
    @(posedge clk);
    wide_i = 1'b0; op_i = op; a_i = a; b_i = b; carry_i = cin; upd_carry_i = upd;
    @(negedge clk);
  endtask

  task automatic check8(input logic [7:0] er, input logic ewe, input logic ez,
                        input logic en, input logic eh, input logic ec);
    chk(res_tag(op_i), res_o, er);
    chk("R6", res_we_o, ewe);
    chk("R8", zero_o, ez);
    chk("R5", sub_o, en);
    chk(half_tag(op_i), half_o, eh);
    chk("R7", carry_o, ec);
  endtask

  // independent model written from the requirements with integer arithmetic
  task automatic sweep_one(input logic [2:0] op, input int a, input int b,
                           input logic cin, input logic upd);
    int c, r, h, co;
    bit arith_sub;
    c = ((op == 3'd1) || (op == 3'd3)) ? int'(cin) : 0;
    arith_sub = (op >= 3'd2) && (op <= 3'd4);
    h = 0; co = 0; r = 0;
    if (op <= 3'd1) begin
      r = a + b + c; h = (((a % 16) + (b % 16) + c) > 15); co = (r > 255);
    end else if (arith_sub) begin
      r = a - b - c; h = ((a % 16) < ((b % 16) + c)); co = (a < (b + c));
    end else if (op == 3'd5) begin
      r = a & b; h = 1;
    end else if (op == 3'd6) begin
      r = a | b;
    end else begin
      r = a ^ b;
    end
    r = r & 255;
    apply8(op, 8'(a), 8'(b), cin, upd);
    check8(8'(r), op != 3'd4, r == 0, arith_sub, h[0], upd ? co[0] : cin);
  endtask

  task automatic check_wide(input logic [15:0] wa, input logic [15:0] wb, input logic zin,
                            input logic upd, input logic [15:0] es, input logic eh,
                            input logic ec);
    @(posedge clk);
    wide_i = 1'b1; wa_i = wa; wb_i = wb; zero_i = zin; upd_carry_i = upd;
    op_i = 3'd4; carry_i = ~ec;
    @(negedge clk);
    chk("R9", wsum_o, es);
    chk("R9", half_o, eh);
    chk("R9", carry_o, ec);
    chk("R9", zero_o, zin);
    chk("R9", sub_o, 1'b0);
    chk("R6", res_we_o, 1'b0);
  endtask

  initial begin
    int pts [7] = '{8'h00, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF, 8'h35};
    // idle: all inputs zero is an add of 0+0
    @(negedge clk);
    check8(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply8(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].cin, TBL[i].upd);
      check8(TBL[i].res, TBL[i].we, TBL[i].z, TBL[i].n, TBL[i].h, TBL[i].c);
    end

    // R2: carry_i must not affect plain sub or compare
    apply8(3'd2, 8'h05, 8'h03, 1'b1, 1'b1);
    check8(8'h02, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    apply8(3'd4, 8'h05, 8'h06, 1'b1, 1'b1);
    check8(8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

    for (int op = 0; op < 8; op++)
      for (int ia = 0; ia < 7; ia++)
        for (int ib = 0; ib < 7; ib++)
          for (int k = 0; k < 4; k++)
            sweep_one(3'(op), pts[ia], pts[ib], k[0], k[1]);

    // R9: carry into bit 12 only, out of bit 16 only, wrap to zero
    check_wide(16'h0FFF, 16'h0001, 1'b1, 1'b0, 16'h1000, 1'b1, 1'b0);
    check_wide(16'h8000, 16'h8000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1);
    check_wide(16'hFFFF, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1);
    check_wide(16'h1234, 16'h4321, 1'b1, 1'b1, 16'h5555, 1'b0, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule